// File: doc/BRIEF.md
# Parallel Port Data and Status Register Front End

This block is the host-facing register slice of a PC-style printer port. A CPU bus with an address, a read strobe, a write strobe and an 8-bit data path reaches two registers. Offset 0 holds an output byte that drives the eight data pins. Offset 1 is a status byte built from the printer's handshake lines and a time-out flag that records an overlong wait on the enhanced bidirectional bus. In standard mode a read of offset 0 returns the live levels on the data pins and not the stored byte.

The time-out flag is set by an internal counter. A cycle-start pulse from the enhanced-mode handshake logic starts it, a peripheral-ready indication stops it, and it sets the flag when it reaches a 10 microsecond limit expressed in system clocks. A select input chooses how software clears the flag: by writing a one to bit 0 of the status offset, or automatically when a status read finishes. A status read freezes the byte it returns for as long as the read strobe stays high.

Top module: `pport_regs`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pd_out` is 0x00 and the time-out flag (status bit 0) is 0.
- R2: A clock with `bus_wr` high and `bus_addr` = 0 loads `bus_wdata` into the data register, visible unchanged on `pd_out` after that edge; a write to any other offset leaves `pd_out` unchanged.
- R3: With `bus_rd` high and `bus_addr` = 0, `bus_rdata` equals `pd_in` combinationally when `mode_epp` = 0, and equals the stored data register when `mode_epp` = 1. With `bus_rd` low, `bus_rdata` is 0x00.
- R4: The status byte at offset 1 is: bit 7 = inverted `busy`, bit 6 = `n_ack`, bit 5 = `paper_end`, bit 4 = `slct`, bit 3 = `n_error`, bits 2 and 1 = 0, bit 0 = time-out flag. The five pin inputs pass through a two-flop synchronizer, so a change is visible after two rising edges.
- R5: In the first cycle of a status read `bus_rdata` shows the current status byte; for the remaining cycles with `bus_rd` high and `bus_addr` held at 1 it keeps exactly that value, whatever the inputs do.
- R6: With `mode_epp` = 1, the rising edge that samples `epp_start` high begins a count; if `epp_ready` is not sampled high, the flag is set by the LIMIT-th rising edge after that one, where LIMIT = `CLK_HZ`/100000 (minimum 2). A sampled `epp_ready` stops the count with no flag. `epp_start` is ignored when `mode_epp` = 0.
- R7: With `tmo_clr_sel` = 0, a write to offset 1 with bit 0 = 1 clears the flag; a write with bit 0 = 0 and the end of a status read leave it set.
- R8: With `tmo_clr_sel` = 1, writes to offset 1 leave the flag unchanged, and the flag clears on the rising edge at which `bus_rd` is first sampled low after a read of offset 1.
- R9: When the count expires in the same clock as a clearing action, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe, held for the read cycle |
| bus_wr | input | 1 | Write strobe, one write per clock it is high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| mode_epp | input | 1 | 1 = enhanced mode, 0 = standard mode |
| tmo_clr_sel | input | 1 | 0 = write-one clear, 1 = clear at end of status read |
| epp_start | input | 1 | Enhanced bus cycle start pulse (synchronous) |
| epp_ready | input | 1 | Peripheral ready indication (synchronous) |
| pd_out | output | 8 | Drive value for the data pins |
| pd_in | input | 8 | Sensed level of the data pins |
| n_error | input | 1 | Printer error line, low = error |
| slct | input | 1 | Printer on-line line |
| paper_end | input | 1 | Paper end line |
| n_ack | input | 1 | Acknowledge line |
| busy | input | 1 | Busy line |

## Verification
The hardest situation to reach is a clearing action landing in the very clock in which the time-out count expires, since the expiry cycle is set only by the distance from the start pulse. The bench first sets the flag with one full time-out, then issues a new start pulse, counts LIMIT-1 falling edges and raises a write-one-clear so that the same rising edge sees both the clear and the expiry. The exact expiry edge is also bracketed by reading the flag one cycle before and at the limit, using a read strobe that rises and falls between two rising edges so it leaves no trace in the design.

// File: rtl/pport_pkg.sv
package pport_pkg;

    localparam int DATA_W   = 8;
    localparam int OFS_DATA = 0;
    localparam int OFS_STAT = 1;
    localparam int PIN_N    = 5;
    localparam int TMO_DIV  = 100000;   // 1 s / 10 us

    typedef struct packed {
        logic busy;
        logic ack_n;
        logic paper_end;
        logic online;
        logic err_n;
    } pin_in_t;

    typedef struct packed {
        logic       busy_n;
        logic       ack_n;
        logic       paper_end;
        logic       online;
        logic       err_n;
        logic [1:0] zero;
        logic       tmo;
    } stat_word_t;

    typedef enum logic [0:0] {
        TMO_IDLE = 1'b0,
        TMO_RUN  = 1'b1
    } tmo_state_e;

    function automatic int tmo_cycles(input int clk_hz);
        int c;
        c = clk_hz / TMO_DIV;
        return (c < 2) ? 2 : c;
    endfunction

    function automatic stat_word_t build_stat(input pin_in_t p, input logic tmo);
        stat_word_t s;
        s.busy_n    = ~p.busy;
        s.ack_n     = p.ack_n;
        s.paper_end = p.paper_end;
        s.online    = p.online;
        s.err_n     = p.err_n;
        s.zero      = 2'b00;
        s.tmo       = tmo;
        return s;
    endfunction

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[i] <= '0;
                end else if (i == 0) begin
                    stage_q[i] <= din;
                end else begin
                    stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pport_tmo.sv
module pport_tmo
    import pport_pkg::*;
#(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic start,
    input  logic ready,
    input  logic clr,
    output logic flag,
    output logic expire
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

    tmo_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    // expiry is judged before any restart in the same clock
    assign expire = en && (state_q == TMO_RUN) && !ready && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TMO_IDLE;
            cnt_q   <= '0;
        end else if (start && en) begin
            state_q <= TMO_RUN;
            cnt_q   <= '0;
        end else if (state_q == TMO_RUN) begin
            if (!en || ready || cnt_q == LAST) begin
                state_q <= TMO_IDLE;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // setting beats clearing so that no expiry is lost
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (expire) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pport_stat.sv
module pport_stat
    import pport_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rd,
    input  logic       sel_stat,
    input  stat_word_t live,
    output stat_word_t shown,
    output logic       rd_end
);
    logic       rd_q;
    logic       was_stat_q;
    stat_word_t snap_q;
    logic       rd_begin;

    assign rd_begin = rd && !rd_q;
    assign shown    = rd_begin ? live : snap_q;
    assign rd_end   = rd_q && !rd && was_stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q       <= 1'b0;
            was_stat_q <= 1'b0;
            snap_q     <= '0;
        end else begin
            rd_q <= rd;
            if (rd_begin) begin
                was_stat_q <= sel_stat;
                if (sel_stat) begin
                    snap_q <= live;
                end
            end else if (!rd) begin
                was_stat_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
    import pport_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              mode_epp,
    input  logic              tmo_clr_sel,
    input  logic              epp_start,
    input  logic              epp_ready,
    output logic [DATA_W-1:0] pd_out,
    input  logic [DATA_W-1:0] pd_in,
    input  logic              n_error,
    input  logic              slct,
    input  logic              paper_end,
    input  logic              n_ack,
    input  logic              busy
);
    localparam int LIMIT = tmo_cycles(CLK_HZ);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    logic [DATA_W-1:0] data_q;
    pin_in_t           pins_raw;
    pin_in_t           pins_sync;
    stat_word_t        stat_live;
    stat_word_t        stat_shown;
    logic              stat_rd_end;
    logic              tmo_flag;
    logic              tmo_expire;
    logic              tmo_clr;
    logic              hit_data;
    logic              hit_stat;

    assign hit_data = (bus_addr == A_DATA);
    assign hit_stat = (bus_addr == A_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (bus_wr && hit_data) begin
            data_q <= bus_wdata;
        end
    end
    assign pd_out = data_q;

    assign pins_raw = '{busy: busy, ack_n: n_ack, paper_end: paper_end,
                        online: slct, err_n: n_error};

    pport_sync #(.W(PIN_N), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_raw),
        .dout (pins_sync)
    );

    assign stat_live = build_stat(pins_sync, tmo_flag);

    pport_stat u_stat (
        .clk      (clk),
        .rst      (rst),
        .rd       (bus_rd),
        .sel_stat (hit_stat),
        .live     (stat_live),
        .shown    (stat_shown),
        .rd_end   (stat_rd_end)
    );

    always_comb begin
        if (tmo_clr_sel) begin
            tmo_clr = stat_rd_end;
        end else begin
            tmo_clr = bus_wr && hit_stat && bus_wdata[0];
        end
    end

    pport_tmo #(.LIMIT(LIMIT)) u_tmo (
        .clk    (clk),
        .rst    (rst),
        .en     (mode_epp),
        .start  (epp_start),
        .ready  (epp_ready),
        .clr    (tmo_clr),
        .flag   (tmo_flag),
        .expire (tmo_expire)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit_data) begin
                bus_rdata = mode_epp ? data_q : pd_in;
            end else if (hit_stat) begin
                bus_rdata = stat_shown;
            end
        end
    end
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        bus_rdata,
    input logic              mode_epp,
    input logic [7:0]        pd_out,
    input logic [7:0]        pd_in,
    input logic              tmo_clr_sel,
    input logic              tmo_flag,
    input logic              tmo_expire
);
    localparam logic [ADDR_W-1:0] A_DATA = '0;
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pd_out == 8'h00 && !tmo_flag));

    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DATA) |=> (pd_out == $past(bus_wdata)));

    a_r2_no_stray_write: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_addr == A_DATA) |=> $stable(pd_out));

    a_r3_spp_passthru: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_DATA && !mode_epp) |-> (bus_rdata == pd_in));

    a_r4_zero_bits: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == A_STAT) |-> (bus_rdata[2:1] == 2'b00));

    a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && $past(bus_rd) && bus_addr == A_STAT && $past(bus_addr) == A_STAT)
        |-> (bus_rdata == $past(bus_rdata)));

    a_r7_w1c: assert property (@(posedge clk) disable iff (rst)
        (!tmo_clr_sel && bus_wr && bus_addr == A_STAT && bus_wdata[0] && !tmo_expire)
        |=> !tmo_flag);

    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        tmo_expire |=> tmo_flag);
endmodule

bind pport_regs pport_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .mode_epp    (mode_epp),
    .pd_out      (pd_out),
    .pd_in       (pd_in),
    .tmo_clr_sel (tmo_clr_sel),
    .tmo_flag    (tmo_flag),
    .tmo_expire  (tmo_expire)
);

// File: tb/sim_pport_regs.sv
`timescale 1ns/1ps
module sim_pport_regs;
    localparam int TB_HZ = 2_000_000;
    localparam int LIM   = TB_HZ / 100000;   // R6 limit in clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       mode_epp = 1'b0, tmo_clr_sel = 1'b0;
    logic       epp_start = 1'b0, epp_ready = 1'b0;
    logic [7:0] pd_out, pd_in = '0;
    logic       n_error = 1'b1, slct = 1'b0, paper_end = 1'b0, n_ack = 1'b1, busy = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    pport_regs #(.CLK_HZ(TB_HZ), .ADDR_W(3)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_epp(mode_epp),
        .tmo_clr_sel(tmo_clr_sel), .epp_start(epp_start), .epp_ready(epp_ready),
        .pd_out(pd_out), .pd_in(pd_in), .n_error(n_error), .slct(slct),
        .paper_end(paper_end), .n_ack(n_ack), .busy(busy)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    function automatic logic [7:0] exp_stat(input logic flag);
        return {~busy, n_ack, paper_end, slct, n_error, 2'b00, flag};
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // read strobe lives only between two rising edges: no state is touched
    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic full_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); epp_start = 1'b1;
        @(negedge clk); epp_start = 1'b0;
    endtask

    task automatic set_flag();
        logic [7:0] v;
        mode_epp = 1'b1;
        pulse_start();
        repeat (LIM) @(negedge clk);
        peek(3'd1, v);
        check("R6 flag set for setup", v & 8'h01, 8'h01);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pd_out in reset", pd_out, 8'h00);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 pd_out after reset", pd_out, 8'h00);
        peek(3'd1, v);
        check("R1 flag after reset", v & 8'h01, 8'h00);
    endtask

    task automatic t_data();
        logic [7:0] v;
        bus_write(3'd0, 8'hA5);
        check("R2 write A5", pd_out, 8'hA5);
        bus_write(3'd0, 8'h3C);
        check("R2 write 3C", pd_out, 8'h3C);
        bus_write(3'd1, 8'hFE);
        check("R2 status write leaves data", pd_out, 8'h3C);
        bus_write(3'd5, 8'h11);
        check("R2 other offset leaves data", pd_out, 8'h3C);
        mode_epp = 1'b0; pd_in = 8'h5A;
        @(negedge clk); peek(3'd0, v);
        check("R3 spp read pins", v, 8'h5A);
        pd_in = 8'hC3; #1 peek(3'd0, v);
        check("R3 spp read pins live", v, 8'hC3);
        mode_epp = 1'b1; #1 peek(3'd0, v);
        check("R3 epp read register", v, 8'h3C);
        #1 check("R3 idle rdata zero", bus_rdata, 8'h00);
        mode_epp = 1'b0;
    endtask

    task automatic t_layout();
        logic [7:0] v;
        @(negedge clk);
        n_error = 1'b0; slct = 1'b1; paper_end = 1'b1; n_ack = 1'b0; busy = 1'b1;
        repeat (3) @(negedge clk);
        peek(3'd1, v);
        check("R4 status pattern A", v, exp_stat(1'b0));
        n_error = 1'b1; slct = 1'b0; paper_end = 1'b0; n_ack = 1'b1; busy = 1'b0;
        @(negedge clk); @(negedge clk);
        peek(3'd1, v);
        check("R4 status pattern B", v, exp_stat(1'b0));
    endtask

    task automatic t_freeze();
        logic [7:0] first;
        logic [7:0] expb;
        @(negedge clk);
        bus_addr = 3'd1; bus_rd = 1'b1;
        #1 first = bus_rdata;
        check("R5 first cycle live", first, exp_stat(1'b0));
        n_error = 1'b0; slct = 1'b1; busy = 1'b1;
        repeat (4) @(negedge clk);
        #1 check("R5 held during read", bus_rdata, first);
        bus_rd = 1'b0;
        repeat (3) @(negedge clk);
        expb = exp_stat(1'b0);
        full_read(3'd1, first);
        check("R5 next read sees new", first, expb);
    endtask

    task automatic t_timeout();
        logic [7:0] v;
        tmo_clr_sel = 1'b0; mode_epp = 1'b1;
        pulse_start();
        repeat (LIM - 1) @(negedge clk);
        peek(3'd1, v);
        check("R6 not set before limit", v & 8'h01, 8'h00);
        @(negedge clk);
        peek(3'd1, v);
        check("R6 set at limit", v & 8'h01, 8'h01);
        bus_write(3'd1, 8'h00);
        peek(3'd1, v);
        check("R7 write zero keeps flag", v & 8'h01, 8'h01);
        full_read(3'd1, v);
        @(negedge clk); peek(3'd1, v);
        check("R7 read end keeps flag", v & 8'h01, 8'h01);
        bus_write(3'd1, 8'h01);
        peek(3'd1, v);
        check("R7 write one clears", v & 8'h01, 8'h00);
        pulse_start();
        repeat (4) @(negedge clk);
        epp_ready = 1'b1;
        @(negedge clk); epp_ready = 1'b0;
        repeat (LIM + 2) @(negedge clk);
        peek(3'd1, v);
        check("R6 ready stops count", v & 8'h01, 8'h00);
        mode_epp = 1'b0;
        pulse_start();
        repeat (LIM + 2) @(negedge clk);
        peek(3'd1, v);
        check("R6 start ignored in spp", v & 8'h01, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        tmo_clr_sel = 1'b0;
        set_flag();
        pulse_start();
        repeat (LIM - 1) @(negedge clk);
        bus_addr = 3'd1; bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        peek(3'd1, v);
        check("R9 expiry beats clear", v & 8'h01, 8'h01);
        bus_write(3'd1, 8'h01);
        peek(3'd1, v);
        check("R7 clear after priority", v & 8'h01, 8'h00);
    endtask

    task automatic t_read_clear();
        logic [7:0] v;
        tmo_clr_sel = 1'b1;
        set_flag();
        bus_write(3'd1, 8'hFF);
        peek(3'd1, v);
        check("R8 write does not clear", v & 8'h01, 8'h01);
        @(negedge clk);
        bus_addr = 3'd1; bus_rd = 1'b1;
        #1 check("R8 read shows flag", bus_rdata & 8'h01, 8'h01);
        repeat (2) @(negedge clk);
        #1 check("R8 flag held in read", bus_rdata & 8'h01, 8'h01);
        bus_rd = 1'b0;
        @(negedge clk);
        peek(3'd1, v);
        check("R8 cleared after read end", v & 8'h01, 8'h00);
        tmo_clr_sel = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_data();
        t_layout();
        t_freeze();
        t_timeout();
        t_priority();
        t_read_clear();
        repeat (2) @(negedge clk);
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end
endmodule